// File: doc/BRIEF.md
# Self-Timed Flash Program and Erase Controller

This block sits between a simple CPU bus and a small on-chip flash array. The array is modelled inside the block as a byte array split into equal pages: several main pages plus one information page, which is the highest page index. A CPU write to a flash address programs exactly one byte. The block holds the CPU off with `wait_o` until an internal program delay has run out. Flash reads are served with no wait state whenever no operation is running.

Erases are started through a four-entry register port and run in the background. A page erase clears the page named in the page register. A mass erase clears every byte, including the information page. When an erase finishes, a DONE flag is set. Software can poll it, or it can raise `irq_o` when enabled. Register accesses go on at full speed while an erase is running. Any flash access made during an erase is stalled until the erase ends. The program, page-erase and mass-erase delays are parameters in clock cycles.

Top module: `flash_seq_ctrl`

## Requirements
- R1: A flash write (`fl_req_i`=1, `fl_we_i`=1) stores `fl_wdata_i` in exactly the one byte at `fl_addr_i`, and leaves every other byte unchanged. Page number = address / PAGE_BYTES.
- R2: `wait_o` is high from the request cycle for PROG_CYC cycles. It goes low in the following cycle, and the byte is committed at the end of that cycle.
- R3: A write request that is still held, with a new address and data, in the cycle after a write completes starts at once. Consecutive writes therefore cost PROG_CYC wait cycles each, with no polling in between.
- R4: After reset every byte reads 8'hFF. When the block is idle, a flash read returns the addressed byte in the request cycle with `wait_o` low.
- R5: Writing register 0 with bit0=1 and bit1=0 starts a page erase of the page held in register 1. The PAGE register holds the page index in its low bits; the value MAIN_PAGES (7) selects the information page, addresses 0x70..0x7F. After PAGE_CYC cycles that page reads 8'hFF and the other pages are unchanged.
- R6: Writing register 0 with bit1=1 starts a mass erase, which wins over bit0. The busy flag (register 2 bit1) stays high for MASS_CYC cycles after the command cycle. After that, every byte reads 8'hFF, including the information page.
- R7: While an erase runs, any flash request is held with `wait_o` high until the erase completes. Register accesses are not stalled, and register 2 bit1 (busy) reads 1.
- R8: Register 2 bit0 (DONE) is set when an erase completes. It is cleared by writing 1 to bit0 of register 2 or by starting a new erase. It reads 0 after reset.
- R9: `irq_o` equals DONE AND register 3 bit0 (interrupt enable).
- R10: An erase command issued while an erase or a program is running is ignored and sets the sticky ERR flag, register 2 bit2. ERR is cleared only by writing 1 to bit2 of register 2.
- R11: If an erase command and a flash access arrive in the same idle cycle, the erase starts first. The access stays stalled until the erase has finished and the access itself has completed.
- R12: Register 1 (PAGE) reads back the value last written to its low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fl_req_i | input | 1 | Flash access request, held until `wait_o` is low |
| fl_we_i | input | 1 | 1 = program byte, 0 = read |
| fl_addr_i | input | 7 | Flash byte address |
| fl_wdata_i | input | 8 | Byte to program |
| fl_rdata_o | output | 8 | Byte read from the addressed location |
| wait_o | output | 1 | Stall for the current flash access |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 command, 1 page, 2 status, 3 interrupt enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Erase-complete interrupt |

## Verification
The timing of each result is fixed relative to the stimulus. A write request sees `wait_o` high for PROG_CYC cycles and low in the next one. An erase keeps busy high for PAGE_CYC or MASS_CYC cycles after the command cycle, and DONE and `irq_o` become visible in the cycle after that. A read during an erase is released in the cycle after the erase ends.

The bench keeps its own reference model, which advances on each rising edge, and compares `wait_o`, `irq_o`, the register read data and any released read data at every falling edge. Directed checks count the stall cycles against these exact figures, then read back array contents through the flash port.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_PROG    = 2'd1,
    OP_PAGE_ER = 2'd2,
    OP_MASS_ER = 2'd3
  } op_e;

  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_PAGE = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_IEN  = 2'd3;
endpackage

// File: rtl/flash_dly_timer.sv
module flash_dly_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          busy_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == CW'(1));

  // R2
  tmr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(len_i)));
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int PAGE_BYTES = 16,
  parameter int PAGES      = 8,
  parameter int AW         = 7,
  parameter int PW         = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prog_i,
  input  logic [AW-1:0] prog_addr_i,
  input  logic [7:0]    prog_data_i,
  input  logic          page_clr_i,
  input  logic [PW-1:0] page_i,
  input  logic          mass_clr_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  localparam int TOTAL = PAGE_BYTES * PAGES;

  logic [7:0] mem_q [TOTAL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TOTAL; i++) mem_q[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < TOTAL; i++) begin
        if (mass_clr_i || (page_clr_i && ((i / PAGE_BYTES) == int'(page_i))))
          mem_q[i] <= 8'hFF;
        else if (prog_i && (int'(prog_addr_i) == i))
          mem_q[i] <= prog_data_i;
      end
    end
  end

  always_comb begin
    rd_data_o = 8'hFF;
    if (int'(rd_addr_i) < TOTAL) rd_data_o = mem_q[rd_addr_i];
  end

  // R6
  mass_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mass_clr_i |=> (mem_q[0] == 8'hFF && mem_q[TOTAL-1] == 8'hFF));
endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
  import flash_ctl_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  input  logic          busy_i,
  input  logic          er_start_i,
  input  logic          er_done_i,
  input  logic          reject_i,
  output logic          pe_cmd_o,
  output logic          me_cmd_o,
  output logic [PW-1:0] page_o,
  output logic          ien_o,
  output logic          done_o,
  output logic          err_o,
  output logic [7:0]    reg_rdata_o
);
  logic [PW-1:0] page_q;
  logic ien_q, done_q, err_q;
  logic wr_cmd, wr_page, wr_stat, wr_ien;
  logic unused_wdata;

  assign wr_cmd  = reg_we_i && (reg_addr_i == RA_CMD);
  assign wr_page = reg_we_i && (reg_addr_i == RA_PAGE);
  assign wr_stat = reg_we_i && (reg_addr_i == RA_STAT);
  assign wr_ien  = reg_we_i && (reg_addr_i == RA_IEN);

  // mass erase wins when both command bits are set
  assign me_cmd_o = wr_cmd && reg_wdata_i[1];
  assign pe_cmd_o = wr_cmd && reg_wdata_i[0] && !reg_wdata_i[1];
  assign unused_wdata = ^reg_wdata_i[7:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      ien_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_page) page_q <= reg_wdata_i[PW-1:0];
      if (wr_ien)  ien_q  <= reg_wdata_i[0];
      if (er_done_i)                       done_q <= 1'b1;
      else if (er_start_i)                 done_q <= 1'b0;
      else if (wr_stat && reg_wdata_i[0])  done_q <= 1'b0;
      if (reject_i)                        err_q  <= 1'b1;
      else if (wr_stat && reg_wdata_i[2])  err_q  <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      RA_PAGE: reg_rdata_o = 8'(page_q);
      RA_STAT: reg_rdata_o = {5'b0, err_q, busy_i, done_q};
      RA_IEN:  reg_rdata_o = {7'b0, ien_q};
      default: reg_rdata_o = 8'h00;
    endcase
  end

  assign page_o = page_q;
  assign ien_o  = ien_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  // R8
  done_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    er_done_i |=> done_q);
  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_i |=> err_q);
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_ctl_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int MAIN_PAGES = 7,
  parameter int PROG_CYC   = 8,
  parameter int PAGE_CYC   = 40,
  parameter int MASS_CYC   = 120,
  localparam int PAGES     = MAIN_PAGES + 1,
  localparam int TOTAL     = PAGE_BYTES * PAGES,
  localparam int AW        = $clog2(TOTAL),
  localparam int PW        = $clog2(PAGES),
  localparam int CW        = $clog2(MASS_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fl_req_i,
  input  logic          fl_we_i,
  input  logic [AW-1:0] fl_addr_i,
  input  logic [7:0]    fl_wdata_i,
  output logic [7:0]    fl_rdata_o,
  output logic          wait_o,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  output logic          irq_o
);
  op_e op_q;
  logic pe_cmd, me_cmd, cmd_any, idle;
  logic start_er, start_pg, reject, fin, ack;
  logic tmr_busy, tmr_last;
  logic [CW-1:0] len;
  logic [AW-1:0] pa_q;
  logic [7:0]    pd_q;
  logic [PW-1:0] page_sel, er_page_q;
  logic ien, done, err;

  assign cmd_any  = pe_cmd | me_cmd;
  assign idle     = (op_q == OP_IDLE);
  assign start_er = idle && cmd_any;
  assign start_pg = idle && !cmd_any && fl_req_i && fl_we_i;
  assign reject   = !idle && cmd_any;
  assign fin      = !idle && tmr_last;
  // idle reads are zero-wait; a program releases in its last cycle
  assign ack      = (idle && !cmd_any && fl_req_i && !fl_we_i) ||
                    ((op_q == OP_PROG) && tmr_last);
  assign wait_o   = fl_req_i && !ack;

  always_comb begin
    if (me_cmd)      len = CW'(MASS_CYC);
    else if (pe_cmd) len = CW'(PAGE_CYC);
    else             len = CW'(PROG_CYC);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= OP_IDLE;
      pa_q      <= '0;
      pd_q      <= '0;
      er_page_q <= '0;
    end else if (start_er) begin
      op_q      <= me_cmd ? OP_MASS_ER : OP_PAGE_ER;
      er_page_q <= page_sel;
    end else if (start_pg) begin
      op_q <= OP_PROG;
      pa_q <= fl_addr_i;
      pd_q <= fl_wdata_i;
    end else if (fin) begin
      op_q <= OP_IDLE;
    end
  end

  flash_dly_timer #(.CW(CW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_er | start_pg),
    .len_i  (len),
    .busy_o (tmr_busy),
    .last_o (tmr_last)
  );

  flash_cell_array #(
    .PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES), .AW(AW), .PW(PW)
  ) u_arr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prog_i      (fin && (op_q == OP_PROG)),
    .prog_addr_i (pa_q),
    .prog_data_i (pd_q),
    .page_clr_i  (fin && (op_q == OP_PAGE_ER)),
    .page_i      (er_page_q),
    .mass_clr_i  (fin && (op_q == OP_MASS_ER)),
    .rd_addr_i   (fl_addr_i),
    .rd_data_o   (fl_rdata_o)
  );

  flash_ctl_regs #(.PW(PW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .busy_i      (!idle),
    .er_start_i  (start_er),
    .er_done_i   (fin && (op_q != OP_PROG)),
    .reject_i    (reject),
    .pe_cmd_o    (pe_cmd),
    .me_cmd_o    (me_cmd),
    .page_o      (page_sel),
    .ien_o       (ien),
    .done_o      (done),
    .err_o       (err),
    .reg_rdata_o (reg_rdata_o)
  );

  assign irq_o = done && ien;

  logic unused_err;
  assign unused_err = err;

  // R2
  prog_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_PROG && fl_req_i && !wait_o) |=> (op_q == OP_IDLE));
  // R2
  tmr_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> !tmr_busy);
  // R7
  erase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_q == OP_PAGE_ER || op_q == OP_MASS_ER) && fl_req_i) |-> wait_o);
endmodule

// File: tb/sim_flash_seq_ctrl.sv
`timescale 1ns/1ps
module sim_flash_seq_ctrl;
  localparam int PB = 16, MP = 7, PROG = 8, PAGE = 40, MASS = 120;
  localparam int TOT = PB * (MP + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic fl_req = 0, fl_we = 0;
  logic [6:0] fl_addr = '0;
  logic [7:0] fl_wdata = '0;
  logic [7:0] fl_rdata;
  logic wait_s;
  logic reg_we = 0;
  logic [1:0] reg_addr = 2'd2;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq;

  int vecs = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  flash_seq_ctrl #(.PAGE_BYTES(PB), .MAIN_PAGES(MP), .PROG_CYC(PROG),
                   .PAGE_CYC(PAGE), .MASS_CYC(MASS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fl_req_i(fl_req), .fl_we_i(fl_we),
    .fl_addr_i(fl_addr), .fl_wdata_i(fl_wdata), .fl_rdata_o(fl_rdata),
    .wait_o(wait_s), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_mem [TOT];
  int m_op, m_left, m_a, m_d, m_pg, m_page, m_ien, m_done, m_err;
  bit m_pe, m_me;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOT; i++) m_mem[i] = 8'hFF;
      m_op = 0; m_left = 0; m_page = 0; m_ien = 0; m_done = 0; m_err = 0;
    end else begin
      cyc++;
      m_pe = reg_we && reg_addr == 0 && reg_wdata[0] && !reg_wdata[1];
      m_me = reg_we && reg_addr == 0 && reg_wdata[1];
      if (reg_we && reg_addr == 1) m_page = reg_wdata[2:0];
      if (reg_we && reg_addr == 3) m_ien = reg_wdata[0];
      if (reg_we && reg_addr == 2) begin
        if (reg_wdata[0]) m_done = 0;
        if (reg_wdata[2]) m_err = 0;
      end
      if (m_op == 0) begin
        if (m_pe || m_me) begin
          m_op = m_me ? 3 : 2; m_left = m_me ? MASS : PAGE; m_pg = m_page; m_done = 0;
        end else if (fl_req && fl_we) begin
          m_op = 1; m_left = PROG; m_a = fl_addr; m_d = fl_wdata;
        end
      end else begin
        if (m_pe || m_me) m_err = 1;
        if (m_left == 1) begin
          if (m_op == 1) m_mem[m_a] = 8'(m_d);
          else begin
            for (int i = 0; i < TOT; i++)
              if (m_op == 3 || i / PB == m_pg) m_mem[i] = 8'hFF;
            m_done = 1;
          end
          m_op = 0;
        end else m_left--;
      end
    end
  end

  bit e_cmd, e_ack, e_wait;
  int e_reg;
  always @(negedge clk) if (rst_n) begin
    e_cmd  = reg_we && reg_addr == 0 && reg_wdata[1:0] != 0;
    e_ack  = (m_op == 0 && !e_cmd && fl_req && !fl_we) || (m_op == 1 && m_left == 1);
    e_wait = fl_req && !e_ack;
    chk("R2", "wait_o", wait_s, e_wait);
    if (fl_req && !fl_we && !e_wait) chk("R1", "fl_rdata_o", fl_rdata, m_mem[fl_addr]);
    chk("R9", "irq_o", irq, m_done & m_ien);
    case (reg_addr)
      2'd1: e_reg = m_page;
      2'd2: e_reg = (m_err << 2) | ((m_op != 0) << 1) | m_done;
      2'd3: e_reg = m_ien;
      default: e_reg = 0;
    endcase
    chk("R8", "reg_rdata_o", reg_rdata, e_reg);
  end

  always @(posedge clk) if (cyc == 100000) begin
    fails++;
    $display("FAIL R3 watchdog: actual %0d cycles expected fewer", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  task automatic reg_wr(input int a, input int d);
    @(posedge clk); #1 reg_we = 1; reg_addr = 2'(a); reg_wdata = 8'(d);
    @(posedge clk); #1 reg_we = 0; reg_addr = 2'd2;
  endtask

  task automatic reg_rd(input int a, output int d);
    @(posedge clk); #1 reg_addr = 2'(a);
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic fl_acc(input bit we, input int a, input int d, output int rd, output int waits);
    @(posedge clk); #1 fl_req = 1; fl_we = we; fl_addr = 7'(a); fl_wdata = 8'(d);
    waits = 0;
    forever begin
      @(negedge clk);
      if (wait_s) waits++; else begin rd = fl_rdata; break; end
    end
    @(posedge clk); #1 fl_req = 0; fl_we = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (reg_rdata[1]) n++; else break;
    end
  endtask

  int rd, w, n, s;
  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    reg_rd(2, s);               chk("R8", "status after reset", s, 0);
    fl_acc(0, 5, 0, rd, w);     chk("R4", "erased byte", rd, 8'hFF);
                                chk("R4", "idle read waits", w, 0);
    reg_wr(1, 3); reg_rd(1, s); chk("R12", "page readback", s, 3);

    fl_acc(1, 8'h12, 8'h5A, rd, w); chk("R2", "program wait cycles", w, PROG);
    fl_acc(0, 8'h12, 0, rd, w);     chk("R1", "programmed byte", rd, 8'h5A);
    fl_acc(0, 8'h13, 0, rd, w);     chk("R1", "neighbour byte", rd, 8'hFF);

    // R3 back-to-back writes, request never dropped
    @(posedge clk); #1 fl_req = 1; fl_we = 1;
    n = 0;
    for (int i = 0; i < 4; i++) begin
      fl_addr = 7'(8'h20 + i); fl_wdata = 8'(8'hA0 + i);
      forever begin @(negedge clk); if (wait_s) n++; else break; end
      @(posedge clk); #1;
    end
    fl_req = 0; fl_we = 0;
    chk("R3", "burst wait cycles", n, 4 * PROG);
    fl_acc(0, 8'h23, 0, rd, w); chk("R3", "last burst byte", rd, 8'hA3);

    // R5 / R7 / R8 / R9 page erase of page 2
    reg_wr(3, 1); reg_wr(1, 2); reg_wr(0, 1);
    reg_rd(2, s);               chk("R7", "busy during erase", s & 3, 2);
    fl_acc(0, 8'h12, 0, rd, w); chk("R7", "read stall cycles", w, PAGE - 2);
                                chk("R7", "read after stall", rd, 8'h5A);
    @(negedge clk);             chk("R9", "irq after erase", irq, 1);
    reg_rd(2, s);               chk("R8", "done set", s, 1);
    fl_acc(0, 8'h20, 0, rd, w); chk("R5", "erased page byte", rd, 8'hFF);
    fl_acc(0, 8'h2F, 0, rd, w); chk("R5", "erased page end", rd, 8'hFF);
    reg_wr(3, 0); @(negedge clk); chk("R9", "irq masked", irq, 0);
    reg_wr(2, 1); reg_rd(2, s);   chk("R8", "done w1c", s, 0);

    // R10 command while busy
    reg_wr(0, 1); reg_wr(0, 2);
    reg_rd(2, s);               chk("R10", "err set", s & 4, 4);
    reg_addr = 2'd2; wait_idle(n);
    fl_acc(0, 8'h12, 0, rd, w); chk("R10", "ignored mass erase", rd, 8'h5A);
    reg_wr(2, 4); reg_rd(2, s); chk("R10", "err cleared, done kept", s, 1);

    // R5 info page erase
    fl_acc(1, 8'h75, 8'h33, rd, w);
    fl_acc(1, 8'h05, 8'h44, rd, w);
    reg_wr(1, MP); reg_wr(0, 1); wait_idle(n);
    chk("R5", "page erase busy cycles", n, PAGE);
    fl_acc(0, 8'h75, 0, rd, w); chk("R5", "info byte erased", rd, 8'hFF);
    fl_acc(0, 8'h05, 0, rd, w); chk("R5", "main byte kept", rd, 8'h44);

    // R11 erase and write in same idle cycle; new erase clears done (R8)
    reg_wr(1, 0);
    @(posedge clk); #1 reg_we = 1; reg_addr = 2'd0; reg_wdata = 8'h01;
    fl_req = 1; fl_we = 1; fl_addr = 7'h06; fl_wdata = 8'h77;
    @(negedge clk); chk("R11", "wait on collision", wait_s, 1);
    @(posedge clk); #1 reg_we = 0; reg_addr = 2'd2;
    n = 1;
    forever begin
      @(negedge clk);
      if (n == 1) chk("R8", "done cleared by new erase", reg_rdata & 1, 0);
      if (wait_s) n++; else break;
    end
    @(posedge clk); #1 fl_req = 0; fl_we = 0;
    chk("R11", "collision wait cycles", n, PAGE + 1 + PROG);
    fl_acc(0, 8'h06, 0, rd, w); chk("R11", "write after erase", rd, 8'h77);
    fl_acc(0, 8'h05, 0, rd, w); chk("R11", "page 0 erased", rd, 8'hFF);

    // R6 mass erase, both command bits set
    fl_acc(1, 8'h7A, 8'h11, rd, w);
    fl_acc(1, 8'h12, 8'h22, rd, w);
    reg_wr(0, 3); wait_idle(n);
    chk("R6", "mass erase busy cycles", n, MASS);
    fl_acc(0, 8'h7A, 0, rd, w); chk("R6", "info page cleared", rd, 8'hFF);
    fl_acc(0, 8'h12, 0, rd, w); chk("R6", "main page cleared", rd, 8'hFF);
    fl_acc(0, 8'h06, 0, rd, w); chk("R6", "page 0 cleared", rd, 8'hFF);

    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule